// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank Tracking

This block sits on the memory side of a double data rate SDRAM command bus. On every rising clock edge it samples the active-low chip select, the three active-low command strobes, a two-bit bank select and a thirteen-bit address. From these it decodes one of seven operations: no-op, row activate, read, write, precharge, refresh and mode load. The decoded command, the bank, the row and the column appear on registered outputs one cycle after the edge.

The block tracks each of four banks. For every bank it holds an open/closed state, the row that is open, and a pending auto-precharge with a countdown that closes the bank once the burst has finished. Address bit 10 has two jobs. On a read or write it asks for an auto-precharge. On a precharge it widens the command to every bank. A command that breaks the bank rules does nothing and raises an error pulse instead.

A mode register holds the burst length, the burst ordering and the read latency. The column field is picked at elaboration time from the device data width (x4, x8 or x16).

Top module: `ddr_cmd_front`

## Requirements
- R1: While `cs_n` is high at a rising edge, the command shown on `cmd_o` one cycle later is NOP (code 0), whatever the strobes carry, and no state changes.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decode as follows: 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 MODE LOAD, and any other code NOP. The result appears on `cmd_o` one cycle after the edge, coded NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5, MODE LOAD=6.
- R3: ACTIVE to a closed bank opens it and stores `addr_i` as that bank's row, and `row_o` shows the row. ACTIVE to a bank that is open, including one with a pending auto-precharge, is rejected.
- R4: READ or WRITE is accepted only when the addressed bank is open and has no pending auto-precharge. When accepted, `row_o` shows the row stored for that bank and `col_o` shows the column.
- R5: With DQ_BITS=16 the column is `addr_i[8:0]`. With DQ_BITS=8 it is `addr_i[9:0]`. With DQ_BITS=4 it is {`addr_i[11]`,`addr_i[9:0]`}. The unused upper bits of `col_o` are zero.
- R6: An accepted READ or WRITE with `addr_i[10]` high sets `ap_o` and the bank's bit in `ap_pend_o`. The bank closes, and the pending bit clears, at the edge BL/2 cycles after the command edge.
- R7: PRECHARGE with `addr_i[10]` low closes only the bank on `ba_i`. With `addr_i[10]` high it closes every bank and sets `all_o`. A precharge cancels any pending auto-precharge on the banks it closes. A precharge to a closed bank is accepted.
- R8: REFRESH and MODE LOAD are accepted only while all banks are closed.
- R9: MODE LOAD reads three fields. `addr_i[2:0]` sets the burst length (001=2, 010=4, 011=8). `addr_i[3]` sets the burst order (1=interleaved). `addr_i[6:4]` sets the latency (010=2, 110=2.5). Any other length or latency code is rejected and leaves the mode unchanged.
- R10: After reset all banks are closed, no auto-precharge is pending, `cmd_o` is NOP, and the mode is burst length 2, sequential, latency 2.
- R11: A rejected command pulses `err_o` for one cycle with `cmd_o` at NOP, and changes no bank or mode state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Row / column / mode address |
| cmd_o | output | 3 | Accepted command code |
| bank_o | output | 2 | Bank of the last bank command |
| row_o | output | 13 | Row opened, or row being accessed |
| col_o | output | 11 | Column of the last read/write |
| ap_o | output | 1 | Current read/write carries auto-precharge |
| all_o | output | 1 | Current precharge covers all banks |
| err_o | output | 1 | Rejected command pulse |
| bank_open_o | output | 4 | Open flag per bank |
| ap_pend_o | output | 4 | Pending auto-precharge per bank |
| burst_len_o | output | 4 | Burst length (2, 4 or 8) |
| interleave_o | output | 1 | Interleaved burst order |
| cl_half_o | output | 1 | Latency 2.5 when set, 2 when clear |

## Verification
A wrong bank state shows on `bank_open_o` in the cycle after the edge that caused it. It also changes how the next command to that bank is judged: a stale open flag turns a legal ACTIVE into an `err_o` pulse, and a missed flag lets a READ through as code 2 instead of rejecting it. A wrong auto-precharge countdown shows as `ap_pend_o` clearing too early or too late against the BL/2 window. A corrupted mode field changes `burst_len_o` at once, and it also stretches or shortens the next auto-precharge window.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5,
      CMD_MRS = 3'd6
   } cmd_e;

   localparam int COL_MAX_W = 11;   // widest column field (x4 devices)
   localparam int AP_BIT    = 10;   // overloaded auto-precharge / all-bank bit
   localparam int HB_W      = 3;    // holds BL/2 up to 4
   localparam int MODE_W    = 7;    // length, order and latency fields

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd_o
);

   always_comb begin
      cmd_o = CMD_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b010:  cmd_o = CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            3'b000:  cmd_o = CMD_MRS;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/ddr_col_map.sv
module ddr_col_map #(
   parameter int DQ_BITS = 16,
   parameter int COL_W   = 11
) (
   input  logic [11:0]      addr_i,
   output logic [COL_W-1:0] col_o
);

   wire unused_addr_bits = &{1'b0, addr_i};

   generate
      if (!(DQ_BITS == 4 || DQ_BITS == 8 || DQ_BITS == 16)) begin : g_bad_dq
         $error("ddr_col_map: DQ_BITS must be 4, 8 or 16");
      end
      if (COL_W < 11) begin : g_bad_colw
         $error("ddr_col_map: COL_W must be at least 11");
      end

      if (DQ_BITS == 16) begin : g_x16
         assign col_o = COL_W'(addr_i[8:0]);
      end else if (DQ_BITS == 8) begin : g_x8
         assign col_o = COL_W'(addr_i[9:0]);
      end else begin : g_x4
         assign col_o = COL_W'({addr_i[11], addr_i[9:0]});
      end
   endgenerate

endmodule

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg
   import ddr_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [MODE_W-1:0] field_i,
   output logic              fields_ok_o,
   output logic [3:0]        burst_len_o,
   output logic              interleave_o,
   output logic              cl_half_o,
   output logic [HB_W-1:0]   half_burst_o
);

   logic [1:0] bl_code_q;
   logic       ilv_q;
   logic       clh_q;

   logic [2:0] bl_in;
   logic [2:0] cl_in;
   logic       bl_ok;
   logic       cl_ok;

   assign bl_in = field_i[2:0];
   assign cl_in = field_i[6:4];
   assign bl_ok = (bl_in == 3'b001) || (bl_in == 3'b010) || (bl_in == 3'b011);
   assign cl_ok = (cl_in == 3'b010) || (cl_in == 3'b110);
   assign fields_ok_o = bl_ok && cl_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bl_code_q <= 2'd1;
         ilv_q     <= 1'b0;
         clh_q     <= 1'b0;
      end else if (load_i) begin
         bl_code_q <= bl_in[1:0];
         ilv_q     <= field_i[3];
         clh_q     <= cl_in[2];
      end
   end

   assign burst_len_o  = 4'd1 << bl_code_q;
   assign half_burst_o = HB_W'(1) << (bl_code_q - 2'd1);
   assign interleave_o = ilv_q;
   assign cl_half_o    = clh_q;

endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state
   import ddr_cmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_i,
   input  logic              rw_i,
   input  logic              ap_i,
   input  logic              pre_i,
   input  logic              pre_all_i,
   input  logic [BA_W-1:0]   bank_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [HB_W-1:0]   half_burst_i,
   output logic [NUM_BANKS-1:0] open_o,
   output logic [NUM_BANKS-1:0] pend_o,
   output logic [ROW_W-1:0]  row_sel_o
);

   logic [NUM_BANKS*ROW_W-1:0] row_flat;

   generate
      for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
         logic             open_q;
         logic             pend_q;
         logic [HB_W-1:0]  cnt_q;
         logic [ROW_W-1:0] row_q;
         logic             hit;

         assign hit = (bank_i == BA_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_q <= 1'b0;
               pend_q <= 1'b0;
               cnt_q  <= '0;
               row_q  <= '0;
            end else if (act_i && hit) begin
               open_q <= 1'b1;
               row_q  <= row_i;
            end else if (pre_i && (hit || pre_all_i)) begin
               open_q <= 1'b0;
               pend_q <= 1'b0;
               cnt_q  <= '0;
            end else if (rw_i && hit && ap_i) begin
               pend_q <= 1'b1;
               cnt_q  <= half_burst_i;
            end else if (pend_q && cnt_q == HB_W'(1)) begin
               open_q <= 1'b0;
               pend_q <= 1'b0;
               cnt_q  <= '0;
            end else if (pend_q) begin
               cnt_q  <= cnt_q - HB_W'(1);
            end
         end

         assign open_o[g] = open_q;
         assign pend_o[g] = pend_q;
         assign row_flat[g*ROW_W +: ROW_W] = row_q;
      end
   endgenerate

   assign row_sel_o = row_flat[bank_i*ROW_W +: ROW_W];

endmodule

// File: rtl/ddr_cmd_front.sv
module ddr_cmd_front
   import ddr_cmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int DQ_BITS   = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cs_n,
   input  logic                         ras_n,
   input  logic                         cas_n,
   input  logic                         we_n,
   input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
   input  logic [ROW_W-1:0]             addr_i,
   output logic [2:0]                   cmd_o,
   output logic [$clog2(NUM_BANKS)-1:0] bank_o,
   output logic [ROW_W-1:0]             row_o,
   output logic [10:0]                  col_o,
   output logic                         ap_o,
   output logic                         all_o,
   output logic                         err_o,
   output logic [NUM_BANKS-1:0]         bank_open_o,
   output logic [NUM_BANKS-1:0]         ap_pend_o,
   output logic [3:0]                   burst_len_o,
   output logic                         interleave_o,
   output logic                         cl_half_o
);

   localparam int BA_W = $clog2(NUM_BANKS);

   generate
      if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
         $error("ddr_cmd_front: NUM_BANKS must be a power of two, at least 2");
      end
      if (ROW_W < 12) begin : g_bad_row
         $error("ddr_cmd_front: ROW_W must be at least 12");
      end
   endgenerate

   cmd_e                 raw_cmd;
   cmd_e                 acc_cmd;
   logic                 ok;
   logic                 fields_ok;
   logic [HB_W-1:0]      half_burst;
   logic [NUM_BANKS-1:0] open_vec;
   logic [NUM_BANKS-1:0] pend_vec;
   logic [NUM_BANKS-1:0] ba_sel;
   logic [ROW_W-1:0]     row_sel;
   logic [COL_MAX_W-1:0] col_next;
   logic                 ba_open;
   logic                 ba_pend;
   logic                 is_act;
   logic                 is_rw;
   logic                 is_pre;
   logic                 is_mrs;
   logic                 a10;

   ddr_cmd_decode u_decode (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd_o (raw_cmd)
   );

   ddr_col_map #(.DQ_BITS(DQ_BITS), .COL_W(COL_MAX_W)) u_col (
      .addr_i (addr_i[11:0]),
      .col_o  (col_next)
   );

   assign ba_sel  = NUM_BANKS'(1) << ba_i;
   assign ba_open = |(open_vec & ba_sel);
   assign ba_pend = |(pend_vec & ba_sel);
   assign a10     = addr_i[AP_BIT];

   // legality is judged on the state held before this edge
   always_comb begin
      ok = 1'b1;
      unique case (raw_cmd)
         CMD_ACT:         ok = !ba_open;
         CMD_RD, CMD_WR:  ok = ba_open && !ba_pend;
         CMD_REF:         ok = (open_vec == '0);
         CMD_MRS:         ok = (open_vec == '0) && fields_ok;
         default:         ok = 1'b1;
      endcase
   end

   assign acc_cmd = ok ? raw_cmd : CMD_NOP;
   assign is_act  = (acc_cmd == CMD_ACT);
   assign is_rw   = (acc_cmd == CMD_RD) || (acc_cmd == CMD_WR);
   assign is_pre  = (acc_cmd == CMD_PRE);
   assign is_mrs  = (acc_cmd == CMD_MRS);

   ddr_mode_reg u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (is_mrs),
      .field_i      (addr_i[MODE_W-1:0]),
      .fields_ok_o  (fields_ok),
      .burst_len_o  (burst_len_o),
      .interleave_o (interleave_o),
      .cl_half_o    (cl_half_o),
      .half_burst_o (half_burst)
   );

   ddr_bank_state #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_i        (is_act),
      .rw_i         (is_rw),
      .ap_i         (a10),
      .pre_i        (is_pre),
      .pre_all_i    (a10),
      .bank_i       (ba_i),
      .row_i        (addr_i),
      .half_burst_i (half_burst),
      .open_o       (open_vec),
      .pend_o       (pend_vec),
      .row_sel_o    (row_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o  <= 3'(CMD_NOP);
         bank_o <= '0;
         row_o  <= '0;
         col_o  <= '0;
         ap_o   <= 1'b0;
         all_o  <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         cmd_o <= 3'(acc_cmd);
         err_o <= !ok;
         ap_o  <= is_rw && a10;
         all_o <= is_pre && a10;
         if (is_act || is_rw || is_pre) bank_o <= ba_i;
         if (is_act) row_o <= addr_i;
         if (is_rw) begin
            row_o <= row_sel;
            col_o <= col_next;
         end
      end
   end

   assign bank_open_o = open_vec;
   assign ap_pend_o   = pend_vec;

endmodule

// File: rtl/ddr_cmd_front_chk.sv
module ddr_cmd_front_chk #(
   parameter int NUM_BANKS = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cs_n,
   input logic [2:0]                   cmd_o,
   input logic [$clog2(NUM_BANKS)-1:0] bank_o,
   input logic                         all_o,
   input logic                         err_o,
   input logic [NUM_BANKS-1:0]         bank_open_o,
   input logic [3:0]                   burst_len_o
);

   logic [NUM_BANKS-1:0] sel;
   assign sel = NUM_BANKS'(1) << bank_o;

   p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> cmd_o == 3'd0);

   p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o == 3'd1 |-> ((bank_open_o & sel) != '0) && (($past(bank_open_o) & sel) == '0));

   p_rw_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 3'd2 || cmd_o == 3'd3) |-> ($past(bank_open_o) & sel) != '0);

   p_pre_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 3'd4 && all_o) |-> bank_open_o == '0);

   p_ref_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o == 3'd5 |-> $past(bank_open_o) == '0);

   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o != 3'd6 |-> $stable(burst_len_o));

   p_err_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> cmd_o == 3'd0);

endmodule

bind ddr_cmd_front ddr_cmd_front_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .cmd_o       (cmd_o),
   .bank_o      (bank_o),
   .all_o       (all_o),
   .err_o       (err_o),
   .bank_open_o (bank_open_o),
   .burst_len_o (burst_len_o)
);

// File: tb/ddr_cmd_front_bench.sv
module ddr_cmd_front_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;

   logic [2:0]  cmd_o;
   logic [1:0]  bank_o;
   logic [12:0] row_o;
   logic [10:0] col_o;
   logic        ap_o, all_o, err_o, interleave_o, cl_half_o;
   logic [3:0]  bank_open_o, ap_pend_o, burst_len_o;

   logic [2:0]  x4_cmd;
   logic [1:0]  x4_bank;
   logic [12:0] x4_row;
   logic [10:0] x4_col;
   logic        x4_ap, x4_all, x4_err, x4_ilv, x4_clh;
   logic [3:0]  x4_open, x4_pend, x4_bl;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   ddr_cmd_front u_ddr_cmd_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba_i(ba), .addr_i(addr), .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o),
      .col_o(col_o), .ap_o(ap_o), .all_o(all_o), .err_o(err_o),
      .bank_open_o(bank_open_o), .ap_pend_o(ap_pend_o), .burst_len_o(burst_len_o),
      .interleave_o(interleave_o), .cl_half_o(cl_half_o)
   );

   ddr_cmd_front #(.DQ_BITS(4)) u_ddr_cmd_front_x4 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba_i(ba), .addr_i(addr), .cmd_o(x4_cmd), .bank_o(x4_bank), .row_o(x4_row),
      .col_o(x4_col), .ap_o(x4_ap), .all_o(x4_all), .err_o(x4_err),
      .bank_open_o(x4_open), .ap_pend_o(x4_pend), .burst_len_o(x4_bl),
      .interleave_o(x4_ilv), .cl_half_o(x4_clh)
   );

   // {cs,ras,cas,we}, ba, addr, expected cmd, expected err, expected open banks
   localparam int NV = 15;
   localparam logic [26:0] VEC [NV] = '{
      {4'b1000, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000},   // R1 cs high
      {4'b0011, 2'd0, 13'h0123, 3'd1, 1'b0, 4'b0001},   // R2 R3 activate b0
      {4'b0011, 2'd0, 13'h0055, 3'd0, 1'b1, 4'b0001},   // R3 R11 b0 already open
      {4'b0011, 2'd2, 13'h1ABC, 3'd1, 1'b0, 4'b0101},   // R3 activate b2
      {4'b0101, 2'd1, 13'h0000, 3'd0, 1'b1, 4'b0101},   // R4 read closed b1
      {4'b0001, 2'd0, 13'h0000, 3'd0, 1'b1, 4'b0101},   // R8 refresh with banks open
      {4'b0100, 2'd2, 13'h0010, 3'd3, 1'b0, 4'b0101},   // R2 write b2
      {4'b0101, 2'd0, 13'h0400, 3'd2, 1'b0, 4'b0101},   // R6 read b0 auto-pre, BL2
      {4'b0111, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0100},   // R6 b0 closed after 1 cycle
      {4'b0010, 2'd2, 13'h0000, 3'd4, 1'b0, 4'b0000},   // R7 single precharge
      {4'b0010, 2'd1, 13'h0400, 3'd4, 1'b0, 4'b0000},   // R7 all-bank, all closed
      {4'b0000, 2'd0, 13'h006B, 3'd6, 1'b0, 4'b0000},   // R9 BL8, interleave, 2.5
      {4'b0000, 2'd0, 13'h0020, 3'd0, 1'b1, 4'b0000},   // R9 bad length code
      {4'b0001, 2'd0, 13'h0000, 3'd5, 1'b0, 4'b0000},   // R8 refresh accepted
      {4'b0110, 2'd0, 13'h0000, 3'd0, 1'b0, 4'b0000}    // R2 unlisted code -> NOP
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = c;
      ba   = b;
      addr = a;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #400000;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset cmd", cmd_o, 0);
      chk("R10 reset open", bank_open_o, 0);
      chk("R10 reset bl", burst_len_o, 2);
      chk("R10 reset mode", {interleave_o, cl_half_o}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][26:23], VEC[i][22:21], VEC[i][20:8]);
         chk($sformatf("R2 vec %0d cmd", i), cmd_o, VEC[i][7:5]);
         chk($sformatf("R11 vec %0d err", i), err_o, VEC[i][4]);
         chk($sformatf("R3 vec %0d open", i), bank_open_o, VEC[i][3:0]);
      end
      chk("R9 burst length kept", burst_len_o, 8);
      chk("R9 order and latency", {interleave_o, cl_half_o}, 2'b11);

      // R4 R5: stored row and column mapping
      step(4'b0011, 2'd1, 13'h0F0F);
      step(4'b0011, 2'd3, 13'h1234);
      step(4'b0100, 2'd1, 13'h0BFF);
      chk("R4 write row", row_o, 13'h0F0F);
      chk("R5 x16 column", col_o, 11'h1FF);
      chk("R5 x4 column", x4_col, 11'h7FF);
      chk("R6 no auto-pre", ap_o, 0);

      // R6: auto-precharge window with BL8 is 4 cycles
      step(4'b0101, 2'd3, 13'h0400);
      chk("R6 ap flag", ap_o, 1);
      chk("R6 pending set", ap_pend_o, 4'b1000);
      step(4'b0101, 2'd3, 13'h0000);
      chk("R4 read pending bank err", err_o, 1);
      step(4'b0011, 2'd3, 13'h0001);
      chk("R3 act pending bank err", err_o, 1);
      step(4'b0111, 2'd0, 13'h0000);
      chk("R6 pending at 3 cycles", ap_pend_o, 4'b1000);
      step(4'b0111, 2'd0, 13'h0000);
      chk("R6 pending cleared", ap_pend_o, 4'b0000);
      chk("R6 bank closed", bank_open_o, 4'b0010);

      // R7: precharge cancels pending auto-precharge
      step(4'b0011, 2'd0, 13'h0007);
      step(4'b0101, 2'd0, 13'h0400);
      chk("R6 pending b0", ap_pend_o, 4'b0001);
      step(4'b0010, 2'd0, 13'h0000);
      chk("R7 pend cancelled", ap_pend_o, 4'b0000);
      chk("R7 single close", bank_open_o, 4'b0010);
      chk("R7 all flag low", all_o, 0);
      step(4'b0010, 2'd0, 13'h0400);
      chk("R7 all close", bank_open_o, 4'b0000);
      chk("R7 all flag", all_o, 1);

      // R10: reset mid-run
      step(4'b0011, 2'd2, 13'h0100);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R10 reset open", bank_open_o, 0);
      chk("R10 reset bl", burst_len_o, 2);
      chk("R10 reset cmd", cmd_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule